// File: doc/BRIEF.md
# Boot-Block Flash Command Interface

This block models the command side of a byte-wide boot-block flash memory. It sits on a simple synchronous bus: one address, a read strobe, a write strobe, one write byte and one read byte. A write that arrives while no setup command is pending is stored as the current command. That command then decides what later reads return: array bytes, identifier codes or the status register. Two-write sequences erase a block or program a single byte. Both finish in the clock that accepts the second write, and completion shows only as bit 7 of the status register.

The array holds 2^AW bytes and is divided into 32 equal units. Each unit is 4 KB at full size (AW=17) and 64 bytes at the default AW=11. The blocks are a large main block, two small data blocks and a two-unit boot block that can never be erased or programmed. A parameter chooses whether the boot block sits at the top or at the bottom of the array. A second parameter inverts the top array address bit to suit boards that wire that pin inverted. On reset the array is loaded with a computed pattern, so that every later read can be predicted.

Top module: `bootblk_flash`

## Requirements
- R1: After reset, commands decode as array reads, status is 0x00 and rd_data is 0x00. The byte at internal index i (the index after any inversion) equals ((i*37 + SEED) mod 256) XOR i[15:8], with SEED defaulting to 0x5C. A read with rd_en high updates rd_data at the next clock edge, and rd_data holds its value while rd_en is low.
- R2: A write accepted while no erase or program setup is pending stores wr_data as the command. Command 0x70 makes reads return status. Command 0xFF, and any other byte without a defined meaning (including 0xB0), makes reads return the array byte at the address.
- R3: With command 0x90, a read at an even address returns 0x89. A read at an odd address returns 0x94 when the boot block is on top, or 0x95 when it is at the bottom.
- R4: Command 0x50 sets status to 0x00. Status only ever holds 0x00 or 0x80.
- R5: Command 0x20 arms an erase. On the next accepted write, data 0xD0 fills every non-boot block containing the address with 0xFF and sets status to 0x80. Any other data changes neither the array nor the status. In both cases the command becomes 0x70.
- R6: Command 0x40 or 0x10 arms a program. The next accepted write stores its byte at the address, sets status to 0x80 and sets the command to 0x70. When the address lies in the boot block, the byte is not stored, but the status and the command change in the same way.
- R7: Block units when the boot block is on top: main 0–27, data1 28, data2 29, boot 30–31. Block units when it is at the bottom: boot 0–1, no block on unit 2, data1 3, main 4–31, data2 4. Erase at a unit in 4–31 therefore clears all of 4–31. Erase at unit 3 clears unit 3 only. Erase at unit 2 or in the boot block clears nothing.
- R8: With inversion enabled, array address bit AW-1 is flipped before any decoding, for both reads and writes.
- R9: With inversion enabled, a write whose bus address has any bit from bit 20 upward set is ignored entirely. Without inversion, such a write is decoded on its low AW bits.
- R10: When rd_en and wr_en are high in the same cycle, the read returns the state before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | BUS_W | Byte address for reads and writes |
| rd_en | input | 1 | Read strobe; result appears on rd_data after the next edge |
| wr_en | input | 1 | Write strobe; wr_data is a command or operand |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |

## Verification
The bench runs a top-boot instance and an inverted bottom-boot instance side by side on the same stimulus, so every address lands in different blocks on the two. It erases data1 in the bottom layout next to the overlapping main/data2 units, and erases at the unmapped unit 2. A design that decoded the overlap wrongly would leave unit 4 stale or wipe unit 3, and one that ignored the gap would clear bytes it should keep. It also programs into each layout's boot block, checking that the store is dropped while status still turns 0x80, and it sends an erase sequence without the confirm byte, which a careless design would act on anyway. It issues high-address writes that only the inverted instance must ignore, and a read paired with a write in one cycle, which exposes a design that forwards the new command into the read.

// File: rtl/bbf_pkg.sv
// Package bbf_pkg: command codes, identifier codes, block-unit boundaries,
// read-source type and the array fill pattern shared by the flash model.
package bbf_pkg;
    localparam int UNIT_BITS  = 5;
    localparam int UNIT_COUNT = 1 << UNIT_BITS;

    localparam logic [7:0] OP_ARRAY       = 8'hFF;
    localparam logic [7:0] OP_IDENT       = 8'h90;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_CLEAR       = 8'h50;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_PROG_ALT    = 8'h10;

    localparam logic [7:0] MFR_CODE   = 8'h89;
    localparam logic [7:0] DEV_TOP    = 8'h94;
    localparam logic [7:0] DEV_BOTTOM = 8'h95;
    localparam logic [7:0] ST_DONE    = 8'h80;
    localparam logic [7:0] ST_IDLE    = 8'h00;

    // Unit boundaries, top-boot layout
    localparam int TOP_MAIN_LAST = UNIT_COUNT - 5;
    localparam int TOP_D1_UNIT   = UNIT_COUNT - 4;
    localparam int TOP_D2_UNIT   = UNIT_COUNT - 3;
    localparam int TOP_BOOT_LO   = UNIT_COUNT - 2;
    // Unit boundaries, bottom-boot layout
    localparam int BOT_BOOT_HI   = 1;
    localparam int BOT_D1_UNIT   = 3;
    localparam int BOT_MAIN_LO   = 4;
    localparam int BOT_D2_UNIT   = 4;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    // Reset content of the byte at internal index idx
    function automatic logic [7:0] fill_pattern(input logic [31:0] idx, input logic [7:0] seed);
        logic [31:0] mix;
        mix = idx * 32'd37 + {24'd0, seed};
        return mix[7:0] ^ idx[15:8];
    endfunction
endpackage

// File: rtl/bbf_addr_front.sv
// Module bbf_addr_front: turns the bus address into the internal array index
// (optionally flipping the top index bit) and qualifies writes.
// Assumes HI_LSB < BUS_W and AW <= HI_LSB.
module bbf_addr_front #(
    parameter int BUS_W  = 32,
    parameter int AW     = 11,
    parameter bit INVERT = 1'b0,
    parameter int HI_LSB = 20
) (
    input  logic [BUS_W-1:0] bus_addr,
    input  logic             wr_en,
    output logic [AW-1:0]    loc_addr,
    output logic             wr_ok
);
    localparam logic [AW-1:0] FLIP = INVERT ? (AW'(1) << (AW - 1)) : '0;

    logic spare_unused;

    // Internal index after optional top-bit inversion
    assign loc_addr = bus_addr[AW-1:0] ^ FLIP;
    // Address bits that the decode ignores
    assign spare_unused = ^bus_addr;

    generate
        if (INVERT) begin : g_inv
            // High-address writes are dropped in inverted mode
            assign wr_ok = wr_en & ~(|bus_addr[BUS_W-1:HI_LSB]);
        end else begin : g_plain
            // Every write is decoded on its low bits
            assign wr_ok = wr_en;
        end
    endgenerate
endmodule

// File: rtl/bbf_block_map.sv
// Module bbf_block_map: for a target unit, gives the mask of units an erase
// there clears (union of all non-boot blocks containing it) and whether the
// unit is in the boot block. Assumes 32 units; BOTTOM picks the layout.
module bbf_block_map import bbf_pkg::*; #(
    parameter bit BOTTOM = 1'b0
) (
    input  logic [UNIT_BITS-1:0]  unit_idx,
    output logic [UNIT_COUNT-1:0] erase_units,
    output logic                  boot_hit
);
    int  t;
    logic t_main, t_d1, t_d2;

    // Block membership of the target unit
    always_comb begin
        t = int'(unit_idx);
        if (BOTTOM) begin
            t_main   = (t >= BOT_MAIN_LO);
            t_d1     = (t == BOT_D1_UNIT);
            t_d2     = (t == BOT_D2_UNIT);
            boot_hit = (t <= BOT_BOOT_HI);
        end else begin
            t_main   = (t <= TOP_MAIN_LAST);
            t_d1     = (t == TOP_D1_UNIT);
            t_d2     = (t == TOP_D2_UNIT);
            boot_hit = (t >= TOP_BOOT_LO);
        end
    end

    generate
        for (genvar u = 0; u < UNIT_COUNT; u++) begin : g_unit
            localparam bit IN_MAIN = BOTTOM ? (u >= BOT_MAIN_LO) : (u <= TOP_MAIN_LAST);
            localparam bit IN_D1   = BOTTOM ? (u == BOT_D1_UNIT) : (u == TOP_D1_UNIT);
            localparam bit IN_D2   = BOTTOM ? (u == BOT_D2_UNIT) : (u == TOP_D2_UNIT);
            // Unit u is cleared if it shares any block with the target
            assign erase_units[u] = (IN_MAIN & t_main) | (IN_D1 & t_d1) | (IN_D2 & t_d2);
        end
    endgenerate
endmodule

// File: rtl/bbf_cmd_ctrl.sv
// Module bbf_cmd_ctrl: holds the current command and status, runs the
// erase and program setup/confirm sequences and selects the read source.
// Assumes wr_ok is already qualified; operations finish in one clock.
module bbf_cmd_ctrl import bbf_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ok,
    input  logic [7:0] wr_data,
    input  logic       boot_hit,
    output logic [7:0] cmd_q,
    output logic [7:0] status_q,
    output logic       do_erase,
    output logic       do_prog,
    output rd_src_e    rd_src
);
    logic erase_armed, prog_armed;

    // Decode pending setups and the strobes they produce
    always_comb begin
        erase_armed = (cmd_q == OP_ERASE_SETUP);
        prog_armed  = (cmd_q == OP_PROG_SETUP) || (cmd_q == OP_PROG_ALT);
        do_erase    = wr_ok && erase_armed && (wr_data == OP_ERASE_GO);
        do_prog     = wr_ok && prog_armed && !boot_hit;
    end

    // Command and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= OP_ARRAY;
            status_q <= ST_IDLE;
        end else if (wr_ok) begin
            if (erase_armed) begin
                cmd_q <= OP_STATUS;
                if (wr_data == OP_ERASE_GO) status_q <= ST_DONE;
            end else if (prog_armed) begin
                cmd_q    <= OP_STATUS;
                status_q <= ST_DONE;
            end else begin
                cmd_q <= wr_data;
                if (wr_data == OP_CLEAR) status_q <= ST_IDLE;
            end
        end
    end

    // Read source chosen by the current command
    always_comb begin
        case (cmd_q)
            OP_IDENT:  rd_src = SRC_IDENT;
            OP_STATUS: rd_src = SRC_STATUS;
            default:   rd_src = SRC_ARRAY;
        endcase
    end
endmodule

// File: rtl/bbf_array.sv
// Module bbf_array: byte array with single-cycle unit-mask erase and single
// byte program; loaded with a computed pattern on reset. Erase wins over
// program (they never coincide). Assumes AW > UNIT_BITS.
module bbf_array import bbf_pkg::*; #(
    parameter int         AW   = 11,
    parameter logic [7:0] SEED = 8'h5C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         loc_addr,
    input  logic [7:0]            wr_data,
    input  logic                  do_erase,
    input  logic                  do_prog,
    input  logic [UNIT_COUNT-1:0] erase_units,
    output logic [7:0]            arr_byte
);
    localparam int DEPTH = 1 << AW;
    localparam int SH    = AW - UNIT_BITS;

    logic [7:0] mem [DEPTH];

    // Reset load, block erase and byte program
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= fill_pattern(32'(i), SEED);
            end else if (do_erase && erase_units[UNIT_BITS'(i >> SH)]) begin
                mem[i] <= 8'hFF;
            end else if (do_prog && (loc_addr == AW'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Combinational array read
    assign arr_byte = mem[loc_addr];
endmodule

// File: rtl/bootblk_flash.sv
// Module bootblk_flash: boot-block flash command interface on a simple
// synchronous bus. Reads are registered (one cycle); a read in the same cycle
// as a write sees the state before that write.
module bootblk_flash import bbf_pkg::*; #(
    parameter int         BUS_W       = 32,
    parameter int         AW          = 11,
    parameter bit         BOTTOM_BOOT = 1'b0,
    parameter bit         INVERT_TOP  = 1'b0,
    parameter int         HI_LSB      = 20,
    parameter logic [7:0] SEED        = 8'h5C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] addr,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);
    localparam logic [7:0] DEV_CODE = BOTTOM_BOOT ? DEV_BOTTOM : DEV_TOP;

    logic [AW-1:0]         loc_addr;
    logic                  wr_ok;
    logic [UNIT_COUNT-1:0] erase_units;
    logic                  boot_hit;
    logic [7:0]            cmd_q;
    logic [7:0]            status_q;
    logic                  do_erase;
    logic                  do_prog;
    rd_src_e               rd_src;
    logic [7:0]            arr_byte;
    logic [7:0]            rd_q;

    bbf_addr_front #(.BUS_W(BUS_W), .AW(AW), .INVERT(INVERT_TOP), .HI_LSB(HI_LSB)) front_i (
        .bus_addr (addr),
        .wr_en    (wr_en),
        .loc_addr (loc_addr),
        .wr_ok    (wr_ok)
    );

    bbf_block_map #(.BOTTOM(BOTTOM_BOOT)) map_i (
        .unit_idx    (loc_addr[AW-1 -: UNIT_BITS]),
        .erase_units (erase_units),
        .boot_hit    (boot_hit)
    );

    bbf_cmd_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .wr_data  (wr_data),
        .boot_hit (boot_hit),
        .cmd_q    (cmd_q),
        .status_q (status_q),
        .do_erase (do_erase),
        .do_prog  (do_prog),
        .rd_src   (rd_src)
    );

    bbf_array #(.AW(AW), .SEED(SEED)) array_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .loc_addr    (loc_addr),
        .wr_data     (wr_data),
        .do_erase    (do_erase),
        .do_prog     (do_prog),
        .erase_units (erase_units),
        .arr_byte    (arr_byte)
    );

    // Registered read data, chosen by the current read source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 8'h00;
        end else if (rd_en) begin
            case (rd_src)
                SRC_IDENT:  rd_q <= loc_addr[0] ? DEV_CODE : MFR_CODE;
                SRC_STATUS: rd_q <= status_q;
                default:    rd_q <= arr_byte;
            endcase
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/bootblk_flash_chk.sv
// Module bootblk_flash_chk: protocol checks for bootblk_flash, bound into
// every instance. Relies only on ports and inter-module signals.
module bootblk_flash_chk import bbf_pkg::*; #(
    parameter int BUS_W  = 32,
    parameter int AW     = 11,
    parameter bit BOTTOM = 1'b0,
    parameter bit INVERT = 1'b0,
    parameter int HI_LSB = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BUS_W-1:0]      addr,
    input logic                  wr_en,
    input logic                  wr_ok,
    input logic [7:0]            wr_data,
    input logic [7:0]            cmd_q,
    input logic [7:0]            status_q,
    input logic                  do_prog,
    input logic [AW-1:0]         loc_addr,
    input logic [UNIT_COUNT-1:0] erase_units
);
    logic [4:0] unit_now;
    logic       in_setup;
    logic       chk_unused;

    assign unit_now   = loc_addr[AW-1 -: 5];
    assign in_setup   = (cmd_q == 8'h20) || (cmd_q == 8'h40) || (cmd_q == 8'h10);
    assign chk_unused = ^{addr[HI_LSB-1:0], loc_addr[AW-6:0]};

    AST_STATUS_TWO_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 8'h00) || (status_q == 8'h80)); // R4

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !in_setup && wr_data == 8'h50) |=> (status_q == 8'h00)); // R4

    AST_SETUP_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && in_setup) |=> (cmd_q == 8'h70)); // R5

    AST_BOOT_NOT_PROGRAMMED: assert property (@(posedge clk) disable iff (!rst_n)
        do_prog |-> !(BOTTOM ? (unit_now < 5'd2) : (unit_now >= 5'd30))); // R6

    AST_BOOT_NOT_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        BOTTOM ? (erase_units[1:0] == 2'b00) : (erase_units[31:30] == 2'b00)); // R7

    AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (INVERT && wr_en && (|addr[BUS_W-1:HI_LSB])) |=> ($stable(cmd_q) && $stable(status_q))); // R9
endmodule

bind bootblk_flash bootblk_flash_chk #(
    .BUS_W(BUS_W), .AW(AW), .BOTTOM(BOTTOM_BOOT), .INVERT(INVERT_TOP), .HI_LSB(HI_LSB)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_ok       (wr_ok),
    .wr_data     (wr_data),
    .cmd_q       (cmd_q),
    .status_q    (status_q),
    .do_prog     (do_prog),
    .loc_addr    (loc_addr),
    .erase_units (erase_units)
);

// File: tb/bootblk_flash_tb_top.sv
// Bench: drives a top-boot plain instance and a bottom-boot inverted instance
// with the same stimulus and compares both against a behavioural model on
// every clock.
module bootblk_flash_tb_top;
    localparam int DEPTH = 2048;
    localparam int U     = DEPTH / 32;
    localparam int WD    = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_i, rd_b;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R1 reset";

    logic [7:0] mdl [2][DEPTH];
    logic [7:0] mcmd [2];
    logic [7:0] mst [2];
    logic [7:0] exp_rd [2];
    bit         bot [2] = '{1'b0, 1'b1};
    bit         inv [2] = '{1'b0, 1'b1};

    always #4 clk = ~clk;

    bootblk_flash dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_i)
    );

    bootblk_flash #(.BOTTOM_BOOT(1'b1), .INVERT_TOP(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b)
    );

    function automatic logic [7:0] pat(input int i);
        int v;
        v = (i * 37 + 'h5C) % 256;
        return 8'(v) ^ 8'((i / 256) % 256);
    endfunction

    function automatic int blk_lo(input int k, input int b);
        int t_lo [4] = '{0, 28*U, 29*U, 30*U};
        int b_lo [4] = '{4*U, 3*U, 4*U, 0};
        return bot[k] ? b_lo[b] : t_lo[b];
    endfunction

    function automatic int blk_hi(input int k, input int b);
        int t_hi [4] = '{28*U-1, 29*U-1, 30*U-1, 32*U-1};
        int b_hi [4] = '{32*U-1, 4*U-1, 5*U-1, 2*U-1};
        return bot[k] ? b_hi[b] : t_hi[b];
    endfunction

    task automatic model(input int k, input bit rd, input bit wr, input logic [31:0] a, input logic [7:0] d);
        int l;
        l = int'(a % DEPTH);
        if (inv[k]) l = l ^ (DEPTH / 2);
        if (rd) begin
            if (mcmd[k] == 8'h90) exp_rd[k] = (l % 2 == 1) ? (bot[k] ? 8'h95 : 8'h94) : 8'h89;
            else if (mcmd[k] == 8'h70) exp_rd[k] = mst[k];
            else exp_rd[k] = mdl[k][l];
        end
        if (wr && !(inv[k] && (a >> 20) != 0)) begin
            if (mcmd[k] == 8'h20) begin
                if (d == 8'hD0) begin
                    for (int b = 0; b < 3; b++)
                        if (l >= blk_lo(k, b) && l <= blk_hi(k, b))
                            for (int j = blk_lo(k, b); j <= blk_hi(k, b); j++) mdl[k][j] = 8'hFF;
                    mst[k] = 8'h80;
                end
                mcmd[k] = 8'h70;
            end else if (mcmd[k] == 8'h40 || mcmd[k] == 8'h10) begin
                if (!(l >= blk_lo(k, 3) && l <= blk_hi(k, 3))) mdl[k][l] = d;
                mst[k]  = 8'h80;
                mcmd[k] = 8'h70;
            end else begin
                mcmd[k] = d;
                if (d == 8'h50) mst[k] = 8'h00;
            end
        end
    endtask

    task automatic compare();
        logic [7:0] got [2];
        got[0] = rd_i;
        got[1] = rd_b;
        for (int k = 0; k < 2; k++) begin
            n_checks++;
            if (got[k] !== exp_rd[k]) begin
                n_fails++;
                $display("FAIL %s inst%0d: actual %02h expected %02h", cur_tag, k, got[k], exp_rd[k]);
            end
        end
    endtask

    task automatic step(input bit rd, input bit wr, input logic [31:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        compare();
        rd_en = rd; wr_en = wr; addr = a; wr_data = d;
        for (int k = 0; k < 2; k++) model(k, rd, wr, a, d);
        cur_tag = tag;
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        step(1'b1, 1'b0, a, 8'h00, tag);
    endtask

    task automatic scan_units(input string tag);
        for (int u = 0; u < 32; u++) rd(32'(u * U + 5), tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD && !done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WD);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < DEPTH; i++) mdl[k][i] = pat(i);
            mcmd[k] = 8'hFF; mst[k] = 8'h00; exp_rd[k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset contents and read latency
        rd(32'h000, "R1 reset read");
        rd(32'h3FF, "R1 reset read");
        rd(32'h7FF, "R1 reset read");
        step(1'b0, 1'b0, 32'h0, 8'h0, "R1 hold");
        // R3 identifier codes
        wr(32'h0, 8'h90, "R3 ident cmd");
        rd(32'h100, "R3 mfr code");
        rd(32'h101, "R3 device code");
        // R2 status and array modes
        wr(32'h0, 8'h70, "R2 status cmd");
        rd(32'h0, "R2 status read");
        wr(32'h0, 8'hB0, "R2 suspend code");
        rd(32'h010, "R2 array after B0");
        wr(32'h0, 8'h33, "R2 unknown code");
        rd(32'h011, "R2 array after unknown");
        wr(32'h0, 8'hFF, "R2 array cmd");
        rd(32'h012, "R2 array read");
        // R8 inverted addressing
        rd(32'h000, "R8 low half");
        rd(32'h400, "R8 high half");
        // R6 program, both setup codes, boot protection
        wr(32'h0, 8'h40, "R6 program setup");
        wr(32'h0A0, 8'hA5, "R6 program byte");
        rd(32'h0A0, "R6 status after program");
        wr(32'h0, 8'hFF, "R6 array cmd");
        rd(32'h0A0, "R6 programmed byte");
        wr(32'h0, 8'h10, "R6 alt setup");
        wr(32'h7C0, 8'h3C, "R6 program top boot");
        rd(32'h7C0, "R6 status boot write");
        wr(32'h0, 8'hFF, "R6 array cmd");
        rd(32'h7C0, "R6 boot byte kept");
        wr(32'h0, 8'h40, "R6 program setup");
        wr(32'h440, 8'h00, "R6 program bottom boot");
        wr(32'h0, 8'hFF, "R6 array cmd");
        rd(32'h440, "R6 bottom boot kept");
        // R4 clear status
        wr(32'h0, 8'h50, "R4 clear cmd");
        rd(32'h0, "R4 array after clear");
        wr(32'h0, 8'h70, "R4 status cmd");
        rd(32'h0, "R4 status cleared");
        // R5 erase without confirm
        wr(32'h0, 8'h20, "R5 erase setup");
        wr(32'h100, 8'h77, "R5 no confirm");
        rd(32'h100, "R5 status unchanged");
        wr(32'h0, 8'hFF, "R5 array cmd");
        rd(32'h100, "R5 array unchanged");
        // R5 R7 erase data1 (top) / main (bottom)
        wr(32'h0, 8'h20, "R5 erase setup");
        wr(32'h700, 8'hD0, "R5 erase confirm");
        rd(32'h700, "R5 status after erase");
        wr(32'h0, 8'hFF, "R7 array cmd");
        scan_units("R7 scan after data1 erase");
        // R7 erase in bottom gap unit / top main
        wr(32'h0, 8'h20, "R7 erase setup");
        wr(32'h480, 8'hD0, "R7 erase gap");
        wr(32'h0, 8'hFF, "R7 array cmd");
        scan_units("R7 scan after gap erase");
        // R7 overlap: program units then erase bottom data1
        for (int u = 19; u <= 27; u += 4) begin
            wr(32'h0, 8'h40, "R6 program setup");
            wr(32'(u * U + 5), 8'h12, "R6 program marker");
        end
        wr(32'h0, 8'h40, "R6 program setup");
        wr(32'(20 * U + 5), 8'h34, "R6 program marker");
        wr(32'h0, 8'h20, "R7 erase setup");
        wr(32'(19 * U), 8'hD0, "R7 erase bottom data1");
        wr(32'h0, 8'hFF, "R7 array cmd");
        scan_units("R7 scan after data1 erase bottom");
        // R9 high-address write
        wr(32'h0010_0000, 8'h90, "R9 high write");
        rd(32'h001, "R9 ident or ignored");
        wr(32'h0, 8'hFF, "R9 array cmd");
        // R10 read and write in one cycle
        step(1'b1, 1'b1, 32'h0A0, 8'h70, "R10 read before write");
        rd(32'h0A0, "R10 status after");
        wr(32'h0, 8'hFF, "R10 array cmd");
        // R7 final full scan
        for (int i = 0; i < DEPTH; i++) rd(32'(i), "R7 final scan");
        step(1'b0, 1'b0, 32'h0, 8'h0, "R7 idle");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule